// File: doc/BRIEF.md
# Externally Clocked Serial Word Transmitter

The block sends a parallel word out on one data line, one bit for each active edge of a clock that arrives from outside the block. That clock usually comes from a separate clock generator that sets the bit rate. The transmitter never drives the clock. It only watches the clock, so the system clock and the serial clock may be unrelated.

A configuration write sets the number of bits per word and chooses between two start modes. In start-stop mode the first bit appears on the line as soon as the word is written. In plain mode the line stays low until the first active edge. A third configuration bit makes the transmitter treat the falling edge of the serial clock as the active edge. The pin itself is not touched. The effect is that data changes half a clock period away from the rising edge, which gives a rising-edge receiver half a period of setup time.

The serial clock passes through a two-stage synchroniser before its edges are detected. Because of this, each new bit appears a fixed two system cycles after the edge is seen. When the word is finished, the block raises a done flag and drives the line low.

Top module: `ext_clk_serial_tx`

## Requirements
- R1: After reset, `txOut` is 0 and `done` is 0.
- R2: A configuration write, taken while no transfer is running, stores the following fields:
  - `cfgWrData[4:0]` holds the word length minus one, so 7 means 8 bits.
  - `cfgWrData[5]` = 1 selects start-stop mode.
  - `cfgWrData[6]` = 1 makes the falling edge of `sclkIn` the active edge.
- R3: In start-stop mode, a data write taken while idle places bit 0 of the word on `txOut` in the cycle after the write. Active edge k (counting from 1) then presents bit k.
- R4: In plain mode, a data write holds `txOut` at 0 until the first active edge. Active edge k then presents bit k-1.
- R5: Bits leave least significant first, and exactly length bits of the word are sent.
- R6: Suppose `sclkIn` changes level and system clock edge c is the first edge to sample the change. If that change is an active edge, `txOut` and `done` take their new values at clock edge c+2 and not earlier.
- R7: The inactive edge of `sclkIn` never changes `txOut`. With inversion set, rising edges are inactive and falling edges are active.
- R8: The last active edge ends the transfer:
  - In start-stop mode the last edge is edge number length.
  - In plain mode it is edge number length+1.
  - At that edge `done` goes to 1 and `txOut` goes to 0.
  - Both stay that way, whatever `sclkIn` does, until the next data write is taken, which clears `done`.
- R9: While a transfer is running, data writes and configuration writes are ignored. The bits already in flight, the word length and the end point do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 7 | Length minus one, start-stop select, clock inversion select |
| dataWrEn | input | 1 | Data word write strobe |
| dataWrData | input | 32 | Word to transmit |
| sclkIn | input | 1 | External serial clock, asynchronous |
| txOut | output | 1 | Serial data output |
| done | output | 1 | Transfer complete flag |

## Verification
The hardest case to reach from the ports is the exact cycle of each data update. To reach it, the bench moves `sclkIn` one level at a time, half a system cycle away from the clock edge. It then samples `txOut` both one cycle before and on the cycle where the new bit must appear. The bench repeats this for every word length from 1 to 32, in every combination of start mode and inversion. At both the rising and the falling transition it checks that only the active one moves the line. Writes that land in the middle of a transfer are placed between edges of an 8-bit start-stop word. The bench then confirms, from the remaining bits and the end point, that the word that was already loaded finishes unchanged.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef struct packed {
    logic load;       // capture a new word
    logic loadFirst;  // on load, present bit 0 at once
    logic shift;      // present next bit
    logic clear;      // end of word, drive line low
  } txStrobe_t;
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWrEn,
  input  logic [$clog2(DATA_W)+1:0]  cfgWrData,
  input  logic                       dataWrEn,
  input  logic                       sclkIn,
  output txStrobe_t                  strobe,
  output logic                       busy,
  output logic                       done
);
  localparam int LEN_W = $clog2(DATA_W);
  localparam int CNT_W = LEN_W + 2;

  logic [LEN_W-1:0] cfgLenM1;
  logic             cfgStartStop;
  logic             cfgInvert;

  // synchroniser chain for the external clock
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   sclkPrev;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= sclkIn;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= syncQ[SYNC_STAGES-1];

  logic curLvl, prvLvl, activeEdge;
  assign curLvl     = syncQ[SYNC_STAGES-1] ^ cfgInvert;
  assign prvLvl     = sclkPrev ^ cfgInvert;
  assign activeEdge = curLvl & ~prvLvl;

  // configuration register
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      cfgLenM1     <= '0;
      cfgStartStop <= 1'b0;
      cfgInvert    <= 1'b0;
    end else if (cfgWrEn && !busy) begin
      cfgLenM1     <= cfgWrData[LEN_W-1:0];
      cfgStartStop <= cfgWrData[LEN_W];
      cfgInvert    <= cfgWrData[LEN_W+1];
    end

  // edge counting
  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] lastEdge;
  logic             accept, finish;

  assign lastEdge = CNT_W'(cfgLenM1) + CNT_W'(1) + CNT_W'(!cfgStartStop);
  assign accept   = dataWrEn && !busy;
  assign finish   = busy && activeEdge && ((edgeCnt + CNT_W'(1)) == lastEdge);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      edgeCnt <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      edgeCnt <= '0;
    end else if (finish) begin
      busy    <= 1'b0;
      done    <= 1'b1;
      edgeCnt <= '0;
    end else if (busy && activeEdge) begin
      edgeCnt <= edgeCnt + CNT_W'(1);
    end

  always_comb begin
    strobe.load      = accept;
    strobe.loadFirst = accept && cfgStartStop;
    strobe.shift     = busy && activeEdge && !finish;
    strobe.clear     = finish;
  end

  AST_BUSY_EXCL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done); // R8
  AST_DATA_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dataWrEn && !activeEdge) |=> (busy && $stable(edgeCnt))); // R9
  AST_CFG_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfgWrEn) |=> ($stable(cfgLenM1) && $stable(cfgStartStop) && $stable(cfgInvert))); // R9
  AST_DONE_FROM_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy)); // R6
endmodule

// File: rtl/sertx_dpath.sv
module sertx_dpath
  import sertx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              txOut
);
  logic [DATA_W-1:0] shReg;
  logic              txReg;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      shReg <= '0;
      txReg <= 1'b0;
    end else if (strobe.load) begin
      if (strobe.loadFirst) begin
        txReg <= wrData[0];
        shReg <= wrData >> 1;
      end else begin
        txReg <= 1'b0;
        shReg <= wrData;
      end
    end else if (strobe.shift) begin
      txReg <= shReg[0];
      shReg <= shReg >> 1;
    end else if (strobe.clear) begin
      txReg <= 1'b0;
    end

  assign txOut = txReg;

  AST_TX_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txReg) |-> $past(strobe.load || strobe.shift || strobe.clear)); // R7
endmodule

// File: rtl/ext_clk_serial_tx.sv
module ext_clk_serial_tx
  import sertx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWrEn,
  input  logic [$clog2(DATA_W)+1:0] cfgWrData,
  input  logic                      dataWrEn,
  input  logic [DATA_W-1:0]         dataWrData,
  input  logic                      sclkIn,
  output logic                      txOut,
  output logic                      done
);
  txStrobe_t strobe;
  logic      busy;

  sertx_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .dataWrEn(dataWrEn), .sclkIn(sclkIn), .strobe(strobe),
    .busy(busy), .done(done)
  );

  sertx_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(dataWrData),
    .txOut(txOut)
  );

  AST_DONE_LINE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !txOut); // R8
endmodule

// File: tb/sim_ext_clk_serial_tx.sv
module sim_ext_clk_serial_tx;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [6:0]  cfgWrData = '0;
  logic        dataWrEn = 1'b0;
  logic [31:0] dataWrData = '0;
  logic        sclkIn = 1'b0;
  logic        txOut, done;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ext_clk_serial_tx u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .dataWrEn(dataWrEn), .dataWrData(dataWrData), .sclkIn(sclkIn),
    .txOut(txOut), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeCfg(input int lenM1, input bit ss, input bit inv);
    cfgWrData = {inv, ss, 5'(lenM1)};
    cfgWrEn = 1'b1;
    waitNeg(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic writeData(input logic [31:0] d);
    dataWrData = d;
    dataWrEn = 1'b1;
    waitNeg(1);
    dataWrEn = 1'b0;
  endtask

  // move sclkIn; for an active edge check latency then new values
  task automatic sclkTo(input bit lvl, input bit active, input bit oldTx,
                        input bit newTx, input bit newDone, input string req);
    sclkIn = lvl;
    waitNeg(2);
    check(txOut == oldTx, "R6", txOut, oldTx);
    waitNeg(1);
    if (active) begin
      check(txOut == newTx, req, txOut, newTx);
      check(done == newDone, "R8", done, newDone);
    end else begin
      check(txOut == oldTx, "R7", txOut, oldTx);
    end
  endtask

  task automatic runWord(input int len, input bit ss, input bit inv,
                         input logic [31:0] d, input bit midWrite);
    int nEdges;
    bit cur, nxt, nd;
    string tag;
    writeCfg(len - 1, ss, inv);
    writeData(d);
    cur = ss ? d[0] : 1'b0;
    check(txOut == cur, ss ? "R3" : "R4", txOut, cur);
    check(done == 1'b0, "R8", done, 0);
    nEdges = ss ? len : len + 1;
    tag = ss ? "R3" : "R4";
    for (int k = 1; k <= nEdges; k++) begin
      nd  = (k == nEdges);
      nxt = nd ? 1'b0 : (ss ? d[k] : d[k-1]);
      if (!inv) begin
        sclkTo(1'b1, 1'b1, cur, nxt, nd, nd ? "R8" : tag);
        cur = nxt;
        sclkTo(1'b0, 1'b0, cur, cur, nd, "R7");
      end else begin
        sclkTo(1'b1, 1'b0, cur, cur, 1'b0, "R7");
        sclkTo(1'b0, 1'b1, cur, nxt, nd, nd ? "R8" : tag);
        cur = nxt;
      end
      if (midWrite && k == 3) begin
        writeData(~d);     // R9: ignored
        writeCfg(31, 1'b0, 1'b1);
        check(txOut == cur, "R9", txOut, cur);
      end
    end
    check(done == 1'b1 && txOut == 1'b0, "R5", {done, txOut}, 2);
    // idle edges after the end do nothing
    for (int j = 0; j < 2; j++) begin
      sclkIn = 1'b1; waitNeg(4);
      sclkIn = 1'b0; waitNeg(4);
    end
    check(done == 1'b1, "R8", done, 1);
    check(txOut == 1'b0, "R8", txOut, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    waitNeg(2);
    check(txOut == 1'b0, "R1", txOut, 0);
    check(done == 1'b0, "R1", done, 0);
    rstN = 1'b1;
    waitNeg(2);
    check(txOut == 1'b0 && done == 1'b0, "R1", {done, txOut}, 0);
    // R2: field encoding exercised by every length/mode sweep below
    for (int len = 1; len <= 32; len++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] d;
        d = (32'h9E3779B9 * 32'(len)) ^ (32'h01234567 * 32'(m + 1));
        runWord(len, m[0], m[1], d, 1'b0);
      end
    end
    // R9: writes during a running 8-bit start-stop word
    runWord(8, 1'b1, 1'b0, 32'h0000_00B4, 1'b1);
    runWord(8, 1'b0, 1'b1, 32'h0000_005A, 1'b1);
    // R2: length field 7 gives exactly 8 bits (end after edge 8 in start-stop)
    runWord(8, 1'b1, 1'b0, 32'hFFFF_FF34, 1'b0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule